// File: doc/BRIEF.md
# UART Channel Command and Mode Registers

This block is the per-channel control register file of a multi-channel UART. A byte-wide register bus with separate read and write strobes reaches a small address window for each channel. Through that window software sets the character format, turns the receiver and transmitter on and off, issues one-shot commands, reads line status and moves data bytes. The shift engines sit outside the block. They receive enables, reset pulses, a break level and the decoded format. They return ready and empty levels plus one-cycle error event pulses.

The mode registers share one address and are selected by an internal pointer. The pointer moves forward on each mode write. Pointer-reset commands are carried in the upper nibble of the command byte, next to four independent enable and disable bits. An optional extended mode register, chosen by a parameter, controls FIFO depth and the transmit-ready threshold. Error flags are sticky until software clears them.

Top module: `uart_chan_ctrl`

## Requirements
- R1: Channel n owns addresses n*8 to n*8+7. Offset 0 is the mode register. Offset 1 reads status and writes clock select. Offset 2 writes commands and reads 0x00. Offset 3 reads receive data and writes transmit data. Offsets 4 to 7 read 0x00 and ignore writes.
- R2: In a command byte, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When the enable and disable bits for one direction are both set, disable wins. These bits act together with any command code in the same write. Both enables reset to 0.
- R3: Command code (bits 7:4) 0x1 sets the mode pointer to MR1. Code 0xB sets it to MR0 when the extended register is present and is ignored otherwise. No other code moves the pointer.
- R4: The mode pointer resets to MR1. A mode write at MR0 loads MR0 and moves to MR1. A mode write at MR1 loads MR1 and moves to MR2. A mode write at MR2 loads MR2 and stays at MR2. A read of offset 0 returns the register under the pointer and does not move the pointer.
- R5: All mode registers reset to 0x00. The format outputs follow the mode registers as follows:
  - character length = MR1[1:0], where 0 to 3 mean 5 to 8 bits;
  - parity = MR1[4:2], where 0 is even, 1 is odd and 4 is none;
  - two-stop is 1 exactly when MR2[3:0] = 0xF (0x7 is one stop bit);
  - deep-FIFO = MR0[3];
  - half-full TX threshold = MR0[4].
- R6: Code 0x2 resets the receiver. It gives a one-cycle receiver reset pulse in the cycle after the write, leaves the receiver disabled even if bit 0 is set, and clears all four error flags. Code 0x3 resets the transmitter. It gives a one-cycle transmitter reset pulse, leaves the transmitter disabled and ends any break.
- R7: Status byte bit 0 is RX ready, bit 1 is RX FIFO full, bit 2 is TX ready, bit 3 is TX empty, bit 4 is overrun, bit 5 is parity error, bit 6 is framing error and bit 7 is received break. Bits 3:0 follow the line inputs directly.
- R8: An event pulse sets its error flag. The flag stays set until one of the following:
  - code 0x4 (clears all four flags);
  - code 0x5 (clears only the break flag);
  - a receiver reset.

  An event in the same cycle as a clear leaves the flag set.
- R9: Code 0x6 raises the break output and code 0x7 lowers it. The break output resets low.
- R10: A write to offset 3 while the transmitter is enabled gives a one-cycle load pulse in the next cycle, with the transmit data output equal to the written byte. While the transmitter is disabled, the write gives no pulse and leaves the data output unchanged.
- R11: A read of offset 3 returns that channel's receive data input in the same cycle. It gives a one-cycle take pulse for that channel in the next cycle. Reads of other offsets give no take pulse.
- R12: A write to offset 1 stores the byte on that channel's clock select output, which resets to 0x00.
- R13: A write to one channel's window changes nothing in any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address: channel index above an 8-address window |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational on address |
| rx_en_o | output | NCH | Receiver enable per channel |
| tx_en_o | output | NCH | Transmitter enable per channel |
| rx_rst_o | output | NCH | One-cycle receiver reset pulse |
| tx_rst_o | output | NCH | One-cycle transmitter reset pulse |
| brk_o | output | NCH | Send-break level |
| clk_sel_o | output | 8*NCH | Clock select byte per channel |
| char_len_o | output | 2*NCH | Character length code per channel |
| parity_o | output | 3*NCH | Parity mode code per channel |
| two_stop_o | output | NCH | Two stop bits selected |
| fifo_deep_o | output | NCH | Deep FIFO enable |
| tx_half_o | output | NCH | TX ready threshold at half full |
| tx_data_o | output | 8*NCH | Transmit byte per channel |
| tx_load_o | output | NCH | One-cycle transmit load pulse |
| rx_data_i | input | 8*NCH | Receive byte per channel |
| rx_take_o | output | NCH | One-cycle receive take pulse |
| rx_rdy_i | input | NCH | Receiver has data |
| rx_full_i | input | NCH | Receive FIFO full |
| tx_rdy_i | input | NCH | Transmitter can accept a byte |
| tx_empty_i | input | NCH | Transmitter fully idle |
| ovr_evt_i | input | NCH | Overrun event pulse |
| par_evt_i | input | NCH | Parity error event pulse |
| frm_evt_i | input | NCH | Framing error event pulse |
| brk_evt_i | input | NCH | Received break event pulse |

## Verification
A mode pointer in the wrong state shows up at once: a mode read returns the wrong register, and after the next mode write the format outputs settle on the wrong values one cycle later. A wrong enable or break state appears on the level outputs in the cycle after the command write. It also shows indirectly through a missing transmit load pulse. Lost or stuck error flags appear on the next status read. Because of this, the bench reads back status and the mode register often between random writes and event pulses.

// File: rtl/uart_cc_pkg.sv
package uart_cc_pkg;

   localparam int unsigned BYTE_W = 8;

   // register offsets inside a channel window
   localparam logic [2:0] OFS_MODE = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd1;
   localparam logic [2:0] OFS_CMD  = 3'd2;
   localparam logic [2:0] OFS_DATA = 3'd3;

   // command codes carried in bits 7:4 of a command byte
   localparam logic [3:0] CMD_PTR_MR1 = 4'h1;
   localparam logic [3:0] CMD_RX_RST  = 4'h2;
   localparam logic [3:0] CMD_TX_RST  = 4'h3;
   localparam logic [3:0] CMD_CLR_ERR = 4'h4;
   localparam logic [3:0] CMD_CLR_BRK = 4'h5;
   localparam logic [3:0] CMD_BRK_ON  = 4'h6;
   localparam logic [3:0] CMD_BRK_OFF = 4'h7;
   localparam logic [3:0] CMD_PTR_MR0 = 4'hB;

   typedef enum logic [1:0] {
      PTR_MR0 = 2'd0,
      PTR_MR1 = 2'd1,
      PTR_MR2 = 2'd2
   } mr_ptr_e;

   // order matches status byte bits 7:4
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
      logic ovr;
   } err_t;

   typedef struct packed {
      logic ptr_mr1;
      logic ptr_mr0;
      logic rx_rst;
      logic tx_rst;
      logic clr_err;
      logic clr_brk;
      logic brk_on;
      logic brk_off;
   } cc_act_t;

endpackage

// File: rtl/uart_cc_cmd.sv
module uart_cc_cmd
   import uart_cc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_i,
   input  logic [7:0] wdata_i,
   output logic       ptr_mr1_o,
   output logic       ptr_mr0_o,
   output logic       clr_all_o,
   output logic       clr_brk_o,
   output logic       rx_en_o,
   output logic       tx_en_o,
   output logic       brk_o,
   output logic       rx_rst_o,
   output logic       tx_rst_o
);

   cc_act_t act;

   always_comb begin
      act = '0;
      if (wr_i) begin
         case (wdata_i[7:4])
            CMD_PTR_MR1: act.ptr_mr1 = 1'b1;
            CMD_PTR_MR0: act.ptr_mr0 = 1'b1;
            CMD_RX_RST:  act.rx_rst  = 1'b1;
            CMD_TX_RST:  act.tx_rst  = 1'b1;
            CMD_CLR_ERR: act.clr_err = 1'b1;
            CMD_CLR_BRK: act.clr_brk = 1'b1;
            CMD_BRK_ON:  act.brk_on  = 1'b1;
            CMD_BRK_OFF: act.brk_off = 1'b1;
            default: ;
         endcase
      end
   end

   assign ptr_mr1_o = act.ptr_mr1;
   assign ptr_mr0_o = act.ptr_mr0;
   assign clr_all_o = act.clr_err | act.rx_rst;
   assign clr_brk_o = act.clr_brk;

   logic rx_en_q, tx_en_q, brk_q, rx_rst_q, tx_rst_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_en_q  <= 1'b0;
         tx_en_q  <= 1'b0;
         brk_q    <= 1'b0;
         rx_rst_q <= 1'b0;
         tx_rst_q <= 1'b0;
      end else begin
         rx_rst_q <= act.rx_rst;
         tx_rst_q <= act.tx_rst;
         if (act.rx_rst || (wr_i && wdata_i[1]))
            rx_en_q <= 1'b0;
         else if (wr_i && wdata_i[0])
            rx_en_q <= 1'b1;
         if (act.tx_rst || (wr_i && wdata_i[3]))
            tx_en_q <= 1'b0;
         else if (wr_i && wdata_i[2])
            tx_en_q <= 1'b1;
         if (act.tx_rst || act.brk_off)
            brk_q <= 1'b0;
         else if (act.brk_on)
            brk_q <= 1'b1;
      end
   end

   assign rx_en_o  = rx_en_q;
   assign tx_en_o  = tx_en_q;
   assign brk_o    = brk_q;
   assign rx_rst_o = rx_rst_q;
   assign tx_rst_o = tx_rst_q;

   // R2: a disable bit always leaves the direction off
   a_r2_rx_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wdata_i[1]) |=> !rx_en_o);
   a_r2_tx_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wdata_i[3]) |=> !tx_en_o);
   // R6: receiver reset pulse comes with the receiver off
   a_r6_rx_rst_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_rst_o |-> !rx_en_o);
   // R9: break only rises after a start-break command
   a_r9_brk_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(brk_o) |-> $past(wr_i && (wdata_i[7:4] == CMD_BRK_ON)));

endmodule

// File: rtl/uart_cc_mode.sv
module uart_cc_mode
   import uart_cc_pkg::*;
#(
   parameter bit HAS_MR0 = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_i,
   input  logic       ptr_mr1_i,
   input  logic       ptr_mr0_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rd_o,
   output logic [1:0] char_len_o,
   output logic [2:0] parity_o,
   output logic       two_stop_o,
   output logic       fifo_deep_o,
   output logic       tx_half_o
);

   mr_ptr_e    ptr_q;
   logic [7:0] mr1_q, mr2_q, mr0_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= PTR_MR1;
      end else if (ptr_mr1_i) begin
         ptr_q <= PTR_MR1;
      end else if (ptr_mr0_i && HAS_MR0) begin
         ptr_q <= PTR_MR0;
      end else if (wr_i) begin
         case (ptr_q)
            PTR_MR0: ptr_q <= PTR_MR1;
            PTR_MR1: ptr_q <= PTR_MR2;
            default: ptr_q <= PTR_MR2;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mr1_q <= '0;
         mr2_q <= '0;
      end else if (wr_i) begin
         if (ptr_q == PTR_MR1) mr1_q <= wdata_i;
         if (ptr_q == PTR_MR2) mr2_q <= wdata_i;
      end
   end

   generate
      if (HAS_MR0) begin : g_mr0
         logic [7:0] mr0_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               mr0_q <= '0;
            else if (wr_i && ptr_q == PTR_MR0)
               mr0_q <= wdata_i;
         end
         assign mr0_w = mr0_q;
      end else begin : g_no_mr0
         assign mr0_w = '0;
         // R3: without the extended register the pointer never selects it
         a_r3_no_mr0: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ptr_q != PTR_MR0);
      end
   endgenerate

   always_comb begin
      case (ptr_q)
         PTR_MR0: rd_o = mr0_w;
         PTR_MR1: rd_o = mr1_q;
         default: rd_o = mr2_q;
      endcase
   end

   assign char_len_o  = mr1_q[1:0];
   assign parity_o    = mr1_q[4:2];
   assign two_stop_o  = (mr2_q[3:0] == 4'hF);
   assign fifo_deep_o = mr0_w[3];
   assign tx_half_o   = mr0_w[4];

   // R4: pointer stays within its three legal states
   a_r4_ptr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_q != 2'd3);
   // R4: pointer parks at MR2 until a pointer command
   a_r4_mr2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ptr_q == PTR_MR2 && !ptr_mr1_i && !ptr_mr0_i) |=> ptr_q == PTR_MR2);
   // R3: point-to-MR1 command always lands on MR1
   a_r3_to_mr1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_mr1_i |=> ptr_q == PTR_MR1);

endmodule

// File: rtl/uart_cc_err.sv
module uart_cc_err
   import uart_cc_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  err_t evt_i,
   input  logic clr_all_i,
   input  logic clr_brk_i,
   output err_t flags_o
);

   logic [3:0] ev;
   logic [3:0] clr_v;
   logic [3:0] flag_q;

   assign ev    = evt_i;
   assign clr_v = {clr_all_i | clr_brk_i, {3{clr_all_i}}};

   generate
      for (genvar i = 0; i < 4; i++) begin : g_flag
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               flag_q[i] <= 1'b0;
            else
               flag_q[i] <= ev[i] | (flag_q[i] & ~clr_v[i]);
         end
         // R8: a flag without a clear keeps its value
         a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_q[i] && !clr_v[i]) |=> flag_q[i]);
         // R8: an event always sets its flag, even against a clear
         a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ev[i] |=> flag_q[i]);
      end
   endgenerate

   assign flags_o = err_t'(flag_q);

endmodule

// File: rtl/uart_cc_chan.sv
module uart_cc_chan
   import uart_cc_pkg::*;
#(
   parameter bit          HAS_MR0  = 1'b1,
   parameter int unsigned WIN_BITS = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sel_i,
   input  logic [WIN_BITS-1:0] off_i,
   input  logic [7:0]          wdata_i,
   input  logic                wr_i,
   input  logic                rd_i,
   output logic [7:0]          rdata_o,
   output logic                rx_en_o,
   output logic                tx_en_o,
   output logic                rx_rst_o,
   output logic                tx_rst_o,
   output logic                brk_o,
   output logic [7:0]          clk_sel_o,
   output logic [1:0]          char_len_o,
   output logic [2:0]          parity_o,
   output logic                two_stop_o,
   output logic                fifo_deep_o,
   output logic                tx_half_o,
   output logic [7:0]          tx_data_o,
   output logic                tx_load_o,
   input  logic [7:0]          rx_data_i,
   output logic                rx_take_o,
   input  logic [3:0]          line_st_i,
   input  err_t                evt_i
);

   localparam logic [WIN_BITS-1:0] A_MODE = WIN_BITS'(OFS_MODE);
   localparam logic [WIN_BITS-1:0] A_STAT = WIN_BITS'(OFS_STAT);
   localparam logic [WIN_BITS-1:0] A_CMD  = WIN_BITS'(OFS_CMD);
   localparam logic [WIN_BITS-1:0] A_DATA = WIN_BITS'(OFS_DATA);

   logic hit_mode, hit_stat, hit_cmd, hit_data;
   assign hit_mode = sel_i && (off_i == A_MODE);
   assign hit_stat = sel_i && (off_i == A_STAT);
   assign hit_cmd  = sel_i && (off_i == A_CMD);
   assign hit_data = sel_i && (off_i == A_DATA);

   logic ptr_mr1, ptr_mr0, clr_all, clr_brk;
   logic [7:0] mode_rd;
   err_t flags;

   uart_cc_cmd u_cmd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_i && hit_cmd),
      .wdata_i   (wdata_i),
      .ptr_mr1_o (ptr_mr1),
      .ptr_mr0_o (ptr_mr0),
      .clr_all_o (clr_all),
      .clr_brk_o (clr_brk),
      .rx_en_o   (rx_en_o),
      .tx_en_o   (tx_en_o),
      .brk_o     (brk_o),
      .rx_rst_o  (rx_rst_o),
      .tx_rst_o  (tx_rst_o)
   );

   uart_cc_mode #(.HAS_MR0(HAS_MR0)) u_mode (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_i && hit_mode),
      .ptr_mr1_i   (ptr_mr1),
      .ptr_mr0_i   (ptr_mr0),
      .wdata_i     (wdata_i),
      .rd_o        (mode_rd),
      .char_len_o  (char_len_o),
      .parity_o    (parity_o),
      .two_stop_o  (two_stop_o),
      .fifo_deep_o (fifo_deep_o),
      .tx_half_o   (tx_half_o)
   );

   uart_cc_err u_err (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i),
      .clr_all_i (clr_all),
      .clr_brk_i (clr_brk),
      .flags_o   (flags)
   );

   logic [7:0] csr_q, txd_q;
   logic       load_q, take_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         csr_q  <= '0;
         txd_q  <= '0;
         load_q <= 1'b0;
         take_q <= 1'b0;
      end else begin
         if (wr_i && hit_stat) csr_q <= wdata_i;
         load_q <= wr_i && hit_data && tx_en_o;
         if (wr_i && hit_data && tx_en_o) txd_q <= wdata_i;
         take_q <= rd_i && hit_data;
      end
   end

   assign clk_sel_o = csr_q;
   assign tx_data_o = txd_q;
   assign tx_load_o = load_q;
   assign rx_take_o = take_q;

   always_comb begin
      rdata_o = '0;
      if (hit_mode)      rdata_o = mode_rd;
      else if (hit_stat) rdata_o = {flags, line_st_i};
      else if (hit_data) rdata_o = rx_data_i;
   end

   // R10: a load pulse only follows a cycle with the transmitter on
   a_r10_load_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_load_o |-> $past(tx_en_o));
   // R6: transmitter reset leaves transmitter off and break ended
   a_r6_tx_rst_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_rst_o |-> (!tx_en_o && !brk_o));
   // R12: clock select only moves on a write
   a_r12_csr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(wr_i) |-> $stable(clk_sel_o));

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
   import uart_cc_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter bit          HAS_MR0  = 1'b1,
   parameter int unsigned WIN_BITS = 3,
   localparam int unsigned CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned ADDR_W  = CH_W + WIN_BITS
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [7:0]          wdata_i,
   input  logic                wr_i,
   input  logic                rd_i,
   output logic [7:0]          rdata_o,
   output logic [NCH-1:0]      rx_en_o,
   output logic [NCH-1:0]      tx_en_o,
   output logic [NCH-1:0]      rx_rst_o,
   output logic [NCH-1:0]      tx_rst_o,
   output logic [NCH-1:0]      brk_o,
   output logic [8*NCH-1:0]    clk_sel_o,
   output logic [2*NCH-1:0]    char_len_o,
   output logic [3*NCH-1:0]    parity_o,
   output logic [NCH-1:0]      two_stop_o,
   output logic [NCH-1:0]      fifo_deep_o,
   output logic [NCH-1:0]      tx_half_o,
   output logic [8*NCH-1:0]    tx_data_o,
   output logic [NCH-1:0]      tx_load_o,
   input  logic [8*NCH-1:0]    rx_data_i,
   output logic [NCH-1:0]      rx_take_o,
   input  logic [NCH-1:0]      rx_rdy_i,
   input  logic [NCH-1:0]      rx_full_i,
   input  logic [NCH-1:0]      tx_rdy_i,
   input  logic [NCH-1:0]      tx_empty_i,
   input  logic [NCH-1:0]      ovr_evt_i,
   input  logic [NCH-1:0]      par_evt_i,
   input  logic [NCH-1:0]      frm_evt_i,
   input  logic [NCH-1:0]      brk_evt_i
);

   generate
      if (NCH < 1 || NCH > 16) begin : g_bad_nch
         $error("uart_chan_ctrl: NCH must lie in 1..16");
      end
      if (WIN_BITS < 2 || WIN_BITS > 6) begin : g_bad_win
         $error("uart_chan_ctrl: WIN_BITS must lie in 2..6");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("uart_chan_ctrl: register bytes must be 8 bits");
      end
   endgenerate

   logic [CH_W-1:0]     ch_idx;
   logic [WIN_BITS-1:0] off;
   assign ch_idx = addr_i[ADDR_W-1:WIN_BITS];
   assign off    = addr_i[WIN_BITS-1:0];

   logic [7:0] ch_rd [NCH];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         err_t evt_c;
         logic sel_c;
         assign evt_c = err_t'({brk_evt_i[c], frm_evt_i[c], par_evt_i[c], ovr_evt_i[c]});
         assign sel_c = (ch_idx == CH_W'(c));

         uart_cc_chan #(.HAS_MR0(HAS_MR0), .WIN_BITS(WIN_BITS)) u_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .sel_i       (sel_c),
            .off_i       (off),
            .wdata_i     (wdata_i),
            .wr_i        (wr_i),
            .rd_i        (rd_i),
            .rdata_o     (ch_rd[c]),
            .rx_en_o     (rx_en_o[c]),
            .tx_en_o     (tx_en_o[c]),
            .rx_rst_o    (rx_rst_o[c]),
            .tx_rst_o    (tx_rst_o[c]),
            .brk_o       (brk_o[c]),
            .clk_sel_o   (clk_sel_o[8*c +: 8]),
            .char_len_o  (char_len_o[2*c +: 2]),
            .parity_o    (parity_o[3*c +: 3]),
            .two_stop_o  (two_stop_o[c]),
            .fifo_deep_o (fifo_deep_o[c]),
            .tx_half_o   (tx_half_o[c]),
            .tx_data_o   (tx_data_o[8*c +: 8]),
            .tx_load_o   (tx_load_o[c]),
            .rx_data_i   (rx_data_i[8*c +: 8]),
            .rx_take_o   (rx_take_o[c]),
            .line_st_i   ({tx_empty_i[c], tx_rdy_i[c], rx_full_i[c], rx_rdy_i[c]}),
            .evt_i       (evt_c)
         );
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int c = 0; c < NCH; c++) rdata_o = rdata_o | ch_rd[c];
   end

   // R11: a read reaches at most one channel's receive register
   a_r11_take_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(rx_take_o));
   // R13: a write loads at most one channel's transmit register
   a_r13_load_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(tx_load_o));
   // R6: at most one channel sees a receiver reset per write
   a_r6_rst_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(rx_rst_o));

endmodule

// File: tb/uart_chan_ctrl_bench.sv
module uart_chan_ctrl_bench;

   localparam int NCH = 2;
   localparam bit HAS_MR0 = 1'b1;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0]    addr = '0;
   logic [7:0]       wdata = '0;
   logic             wr = 1'b0, rd = 1'b0;
   logic [7:0]       rdata;
   logic [NCH-1:0]   rx_en_o, tx_en_o, rx_rst_o, tx_rst_o, brk_o;
   logic [8*NCH-1:0] clk_sel_o, tx_data_o;
   logic [2*NCH-1:0] char_len_o;
   logic [3*NCH-1:0] parity_o;
   logic [NCH-1:0]   two_stop_o, fifo_deep_o, tx_half_o, tx_load_o, rx_take_o;
   logic [8*NCH-1:0] rx_data = '0;
   logic [NCH-1:0]   rx_rdy = '0, rx_full = '0, tx_rdy = '0, tx_empty = '0;
   logic [NCH-1:0]   ovr_e = '0, par_e = '0, frm_e = '0, brk_e = '0;

   uart_chan_ctrl #(.NCH(NCH), .HAS_MR0(HAS_MR0)) u_uart_chan_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
      .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
      .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .rx_rst_o(rx_rst_o), .tx_rst_o(tx_rst_o),
      .brk_o(brk_o), .clk_sel_o(clk_sel_o), .char_len_o(char_len_o), .parity_o(parity_o),
      .two_stop_o(two_stop_o), .fifo_deep_o(fifo_deep_o), .tx_half_o(tx_half_o),
      .tx_data_o(tx_data_o), .tx_load_o(tx_load_o), .rx_data_i(rx_data), .rx_take_o(rx_take_o),
      .rx_rdy_i(rx_rdy), .rx_full_i(rx_full), .tx_rdy_i(tx_rdy), .tx_empty_i(tx_empty),
      .ovr_evt_i(ovr_e), .par_evt_i(par_e), .frm_evt_i(frm_e), .brk_evt_i(brk_e)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference model
   int         m_ptr [NCH];
   logic [7:0] m_mr  [NCH][3];
   logic       m_rxen [NCH], m_txen [NCH], m_brk [NCH];
   logic [3:0] m_err [NCH];
   logic [7:0] m_csr [NCH], m_txd [NCH];

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         m_ptr[c] = 1;
         for (int k = 0; k < 3; k++) m_mr[c][k] = 8'h00;
         m_rxen[c] = 0; m_txen[c] = 0; m_brk[c] = 0;
         m_err[c] = 4'h0; m_csr[c] = 8'h00; m_txd[c] = 8'h00;
      end
   endtask

   task automatic check_state();
      for (int c = 0; c < NCH; c++) begin
         check("R2", $sformatf("rx_en ch%0d", c), 32'(rx_en_o[c]), 32'(m_rxen[c]));
         check("R2", $sformatf("tx_en ch%0d", c), 32'(tx_en_o[c]), 32'(m_txen[c]));
         check("R9", $sformatf("brk ch%0d", c), 32'(brk_o[c]), 32'(m_brk[c]));
         check("R5", $sformatf("char_len ch%0d", c), 32'(char_len_o[2*c +: 2]), 32'(m_mr[c][1][1:0]));
         check("R5", $sformatf("parity ch%0d", c), 32'(parity_o[3*c +: 3]), 32'(m_mr[c][1][4:2]));
         check("R5", $sformatf("two_stop ch%0d", c), 32'(two_stop_o[c]), 32'(m_mr[c][2][3:0] == 4'hF));
         check("R5", $sformatf("fifo_deep ch%0d", c), 32'(fifo_deep_o[c]), 32'(m_mr[c][0][3]));
         check("R5", $sformatf("tx_half ch%0d", c), 32'(tx_half_o[c]), 32'(m_mr[c][0][4]));
         check("R12", $sformatf("clk_sel ch%0d", c), 32'(clk_sel_o[8*c +: 8]), 32'(m_csr[c]));
         check("R10", $sformatf("tx_data ch%0d", c), 32'(tx_data_o[8*c +: 8]), 32'(m_txd[c]));
      end
   endtask

   task automatic do_wr(int ch, int off, logic [7:0] d, logic [3:0] ev = 4'h0);
      logic [NCH-1:0] e_rxrst = '0, e_txrst = '0, e_load = '0;
      @(negedge clk);
      addr = AW'(ch * 8 + off); wdata = d; wr = 1'b1;
      ovr_e[ch] = ev[0]; par_e[ch] = ev[1]; frm_e[ch] = ev[2]; brk_e[ch] = ev[3];
      case (off)
         0: begin
            m_mr[ch][m_ptr[ch]] = d;
            if (m_ptr[ch] < 2) m_ptr[ch]++;
         end
         1: m_csr[ch] = d;
         2: begin
            if (d[1]) m_rxen[ch] = 0; else if (d[0]) m_rxen[ch] = 1;
            if (d[3]) m_txen[ch] = 0; else if (d[2]) m_txen[ch] = 1;
            case (d[7:4])
               4'h1: m_ptr[ch] = 1;
               4'h2: begin m_rxen[ch] = 0; m_err[ch] = 4'h0; e_rxrst[ch] = 1'b1; end
               4'h3: begin m_txen[ch] = 0; m_brk[ch] = 0; e_txrst[ch] = 1'b1; end
               4'h4: m_err[ch] = 4'h0;
               4'h5: m_err[ch][3] = 1'b0;
               4'h6: m_brk[ch] = 1;
               4'h7: m_brk[ch] = 0;
               4'hB: if (HAS_MR0) m_ptr[ch] = 0;
               default: ;
            endcase
         end
         3: if (m_txen[ch]) begin m_txd[ch] = d; e_load[ch] = 1'b1; end
         default: ;
      endcase
      m_err[ch] = m_err[ch] | ev;
      @(negedge clk);
      wr = 1'b0; ovr_e = '0; par_e = '0; frm_e = '0; brk_e = '0;
      check("R6", "rx_rst pulse", 32'(rx_rst_o), 32'(e_rxrst));
      check("R6", "tx_rst pulse", 32'(tx_rst_o), 32'(e_txrst));
      check("R10", "tx_load pulse", 32'(tx_load_o), 32'(e_load));
      check_state();
   endtask

   task automatic do_rd(int ch, int off, logic [7:0] exp, string tag);
      @(negedge clk);
      addr = AW'(ch * 8 + off); rd = 1'b1;
      #1 check(tag, $sformatf("read ch%0d off%0d", ch, off), 32'(rdata), 32'(exp));
      @(negedge clk);
      rd = 1'b0;
      check("R11", "rx_take pulse", 32'(rx_take_o), (off == 3) ? (32'd1 << ch) : 32'd0);
   endtask

   task automatic do_evt(int ch, logic [3:0] ev);
      @(negedge clk);
      ovr_e[ch] = ev[0]; par_e[ch] = ev[1]; frm_e[ch] = ev[2]; brk_e[ch] = ev[3];
      @(negedge clk);
      ovr_e = '0; par_e = '0; frm_e = '0; brk_e = '0;
      m_err[ch] = m_err[ch] | ev;
   endtask

   function automatic logic [7:0] exp_stat(int ch);
      return {m_err[ch], tx_empty[ch], tx_rdy[ch], rx_full[ch], rx_rdy[ch]};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] codes [10];
      logic [7:0] keep;
      codes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'h9};
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check_state();
      check("R6", "rx_rst after reset", 32'(rx_rst_o), 32'd0);
      do_rd(0, 0, 8'h00, "R4");
      do_rd(0, 1, 8'h00, "R7");

      // R4: pointer walk MR1 -> MR2 and park
      do_wr(0, 2, 8'h10);
      do_wr(0, 0, 8'h13);
      do_wr(0, 0, 8'h0F);
      do_wr(0, 0, 8'h07);
      do_rd(0, 0, 8'h07, "R4");
      check("R4", "mr1 kept after MR2 writes", 32'(char_len_o[1:0]), 32'd3);
      do_wr(0, 2, 8'h10);
      do_rd(0, 0, 8'h13, "R4");

      // R3: point at MR0, write it, pointer moves to MR1
      do_wr(0, 2, 8'hB0);
      do_wr(0, 0, 8'h18);
      check("R3", "fifo_deep from MR0", 32'(fifo_deep_o[0]), 32'd1);
      do_rd(0, 0, 8'h13, "R4");

      // R2: enables, disable wins
      do_wr(0, 2, 8'h05);
      do_wr(0, 2, 8'h03);
      check("R2", "rx disable wins", 32'(rx_en_o[0]), 32'd0);
      check("R2", "tx stays on", 32'(tx_en_o[0]), 32'd1);

      // R6: receiver reset overrides enable bit
      do_wr(0, 2, 8'h25);
      check("R6", "rx off after rx reset", 32'(rx_en_o[0]), 32'd0);

      // R8: sticky errors and selective clears
      tx_empty[0] = 1'b1; rx_rdy[0] = 1'b1;
      do_evt(0, 4'hF);
      do_rd(0, 1, exp_stat(0), "R8");
      check("R7", "status layout", 32'(exp_stat(0)), 32'hF9);
      do_wr(0, 2, 8'h50);
      do_rd(0, 1, 8'h79, "R8");
      do_wr(0, 2, 8'h40, 4'h1);
      do_rd(0, 1, 8'h19, "R8");
      do_wr(0, 2, 8'h21);
      do_rd(0, 1, 8'h09, "R8");

      // R9: break on/off, ended by transmitter reset
      do_wr(0, 2, 8'h60);
      do_wr(0, 2, 8'h70);
      do_wr(0, 2, 8'h60);
      do_wr(0, 2, 8'h30);
      check("R9", "tx reset ends break", 32'(brk_o[0]), 32'd0);

      // R10: transmit write ignored while disabled
      do_wr(0, 3, 8'hA5);
      check("R10", "no load while off", 32'(tx_data_o[7:0]), 32'd0);
      do_wr(0, 2, 8'h04);
      do_wr(0, 3, 8'h5A);

      // R11: receive read and take pulse
      rx_data = 16'hC3_3C;
      do_rd(1, 3, 8'hC3, "R11");
      do_rd(0, 3, 8'h3C, "R11");
      do_rd(0, 2, 8'h00, "R1");

      // R1: unused offsets
      do_wr(0, 5, 8'hFF);
      do_rd(0, 6, 8'h00, "R1");
      do_rd(1, 1, exp_stat(1), "R1");

      // R12, R13: clock select and isolation
      keep = clk_sel_o[7:0];
      do_wr(1, 1, 8'hBB);
      check("R13", "ch0 clk_sel untouched", 32'(clk_sel_o[7:0]), 32'(keep));
      do_wr(1, 0, 8'h1F);
      check("R13", "ch0 format untouched", 32'(char_len_o[1:0]), 32'd3);

      // constrained random phase
      for (int it = 0; it < 600; it++) begin
         int ch, kind;
         logic [7:0] d;
         logic [3:0] ev;
         ch = int'($urandom % NCH);
         kind = int'($urandom % 8);
         rx_rdy = NCH'($urandom); rx_full = NCH'($urandom);
         tx_rdy = NCH'($urandom); tx_empty = NCH'($urandom);
         rx_data = 16'($urandom);
         ev = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
         d = 8'($urandom);
         case (kind)
            0, 1: do_wr(ch, 2, {codes[$urandom % 10], d[3:0]}, ev);
            2: do_wr(ch, 0, d, ev);
            3: do_wr(ch, int'($urandom % 8), d, ev);
            4: do_rd(ch, 1, exp_stat(ch), "R7");
            5: do_rd(ch, 0, m_mr[ch][m_ptr[ch]], "R4");
            6: do_rd(ch, 3, rx_data[8*ch +: 8], "R11");
            default: begin
               do_evt(ch, ev);
               do_rd(ch, 1, exp_stat(ch), "R8");
            end
         endcase
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule